// File: doc/BRIEF.md
# Flash Command-Write Qualifier with Supply Lockout

This block sits between a parallel NOR flash bus and the command register behind it. It samples the active-low chip enable, write enable and output enable pins, a low-supply flag and a power-ramp flag. From these it decides whether a bus write is a real command write. When a legal write cycle ends, it emits a single-cycle command strobe together with the address and data it captured. Noise and unsafe conditions produce nothing.

Every input first passes through a multi-stage synchronizer. The three enables then pass through a width filter, so a pulse shorter than `MIN_PULSE` clock cycles never reaches the qualifier.

The qualifier opens a write cycle only when chip enable and write enable are low, output enable is high and the supply is not low. The cycle closes when either enable returns high. A low supply aborts any open cycle and raises a reset-to-read request for the downstream command state machine. Two further guards need a fresh enable cycle before a write can count:
- Enables that were already low when the supply recovered do not start a write.
- Enables that were low during the power ramp do not start a write; the first rising edge after the ramp is swallowed.

Top module: `flash_wr_gate`

## Requirements
- R1: One `cmd_wr` pulse, exactly one clock wide, is produced for each write cycle. A write cycle opens while the filtered chip enable and write enable are both low (0) and the filtered output enable is high (1). It ends when either chip enable or write enable goes high.
- R2: No write cycle opens while output enable is low, chip enable is high or write enable is high. A filtered output-enable fall inside an open cycle abandons that cycle without a strobe.
- R3: While `supply_low` is 1, no strobe is produced and any open write cycle is abandoned.
- R4: `rd_reset_req` equals `supply_low` delayed by exactly `SYNC_STAGES` clock edges.
- R5: Leaving lockout with the enables still low produces no write. Only a new cycle that starts with chip enable or write enable high produces one.
- R6: If chip enable and write enable are both low while `pwr_ramp` is 1, the next cycle end produces no strobe.
- R7: The power-ramp suppression ends once chip enable or write enable is seen high with `pwr_ramp` at 0. The next complete write cycle is then delivered normally.
- R8: A low pulse on chip enable or write enable lasting fewer than `MIN_PULSE` cycles neither opens nor closes a cycle; a pulse of `MIN_PULSE` or more does. An output-enable low pulse shorter than `MIN_PULSE` inside an open cycle does not abandon it.
- R9: `cmd_addr` and `cmd_data` take the values of `addr_in` and `data_in` at the edge that raises `cmd_wr`. They change at no other time.
- R10: `cmd_wr` rises `SYNC_STAGES + MIN_PULSE + 1` clock edges after the bus edge that ends the cycle. Counting starts at the first edge that samples the new pin level.
- R11: After reset, `cmd_wr` and `rd_reset_req` are 0 and no strobe appears while the enables stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| supply_low | input | 1 | Supply below lockout threshold, active high |
| pwr_ramp | input | 1 | Supply is ramping up, active high |
| addr_in | input | AW | Bus address, held until the strobe |
| data_in | input | DW | Bus data, held until the strobe |
| cmd_wr | output | 1 | One-cycle qualified command write |
| cmd_addr | output | AW | Address captured with the strobe |
| cmd_data | output | DW | Data captured with the strobe |
| rd_reset_req | output | 1 | Request to return the command logic to read mode |

## Verification
With the default two synchronizer stages and a three-cycle filter, a pin change reaches the qualifier on the fifth edge after it is driven. The strobe therefore appears after the sixth edge, and `rd_reset_req` follows the supply flag after the second edge. The bench probes the strobe one edge before and one edge after its due point. It probes the lockout request in the same way. All other scenarios hold each pin level for at least a dozen cycles, well past the five-edge path. They then count strobes only once the pipeline has drained, so the result does not depend on the exact cycle.

// File: rtl/fwg_pkg.sv
`timescale 1ns/1ps
package fwg_pkg;
   typedef enum logic {
      QS_IDLE  = 1'b0,
      QS_OPEN  = 1'b1
   } qual_state_e;

   // bit positions inside the synchronized pin vector
   localparam int PIN_CE   = 0;
   localparam int PIN_WE   = 1;
   localparam int PIN_OE   = 2;
   localparam int PIN_LOW  = 3;
   localparam int PIN_RAMP = 4;
   localparam int NUM_PINS = 5;
   localparam int NUM_ENAB = 3;
endpackage

// File: rtl/fwg_sync.sv
`timescale 1ns/1ps
module fwg_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fwg_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("fwg_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fwg_deglitch.sv
`timescale 1ns/1ps
module fwg_deglitch #(
   parameter int MIN_PULSE = 3,
   parameter bit RST_VAL   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (MIN_PULSE < 1) begin : g_bad_pulse
         $error("fwg_deglitch: MIN_PULSE must be at least 1");
      end

      if (MIN_PULSE == 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout <= RST_VAL;
            else        dout <= din;
         end
      end else begin : g_count
         localparam int             CW   = $clog2(MIN_PULSE);
         localparam logic [CW-1:0]  LAST = CW'(MIN_PULSE - 1);
         logic [CW-1:0] run;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run  <= '0;
               dout <= RST_VAL;
            end else if (din == dout) begin
               run  <= '0;
            end else if (run == LAST) begin
               dout <= din;
               run  <= '0;
            end else begin
               run  <= run + 1'b1;
            end
         end

         AST_FLIP_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(dout) |-> ($past(run) == LAST)); // R8
      end
   endgenerate

   AST_FLIP_TO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout) |-> (dout == $past(din))); // R8
endmodule

// File: rtl/fwg_qualify.sv
`timescale 1ns/1ps
module fwg_qualify
   import fwg_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          f_ce_n,
   input  logic          f_we_n,
   input  logic          f_oe_n,
   input  logic          lock,
   input  logic          ramp,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   output logic          cmd_wr,
   output logic [AW-1:0] cmd_addr,
   output logic [DW-1:0] cmd_data
);
   qual_state_e state;
   logic        ready;     // an enable has been high since the last cycle start or lockout
   logic        pu_sup;    // enables were low during the power ramp
   logic        both_low;
   logic        ended;
   logic        open_now;

   assign both_low = !f_ce_n && !f_we_n;
   assign ended    = f_ce_n || f_we_n;
   assign open_now = (state == QS_IDLE) && ready && both_low && f_oe_n && !lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= QS_IDLE;
         ready    <= 1'b0;
         pu_sup   <= 1'b0;
         cmd_wr   <= 1'b0;
         cmd_addr <= '0;
         cmd_data <= '0;
      end else begin
         cmd_wr <= 1'b0;

         if (lock)          ready <= 1'b0;
         else if (ended)    ready <= 1'b1;
         else if (open_now) ready <= 1'b0;

         if (ramp && both_low)    pu_sup <= 1'b1;
         else if (!ramp && ended) pu_sup <= 1'b0;

         case (state)
            QS_IDLE: begin
               if (open_now) state <= QS_OPEN;
            end
            QS_OPEN: begin
               if (lock || !f_oe_n) begin
                  state <= QS_IDLE;
               end else if (ended) begin
                  state <= QS_IDLE;
                  if (!pu_sup) begin
                     cmd_wr   <= 1'b1;
                     cmd_addr <= addr_in;
                     cmd_data <= data_in;
                  end
               end
            end
            default: state <= QS_IDLE;
         endcase
      end
   end

   AST_STROBE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> !cmd_wr); // R1
   AST_OE_HIGH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> $past(f_oe_n)); // R2
   AST_NO_WR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> !$past(lock)); // R3
   AST_RAMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> !$past(pu_sup)); // R6
   AST_ADDR_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmd_addr) |-> cmd_wr); // R9
   AST_DATA_ONLY_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmd_data) |-> cmd_wr); // R9
endmodule

// File: rtl/flash_wr_gate.sv
`timescale 1ns/1ps
module flash_wr_gate
   import fwg_pkg::*;
#(
   parameter int AW          = 8,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_PULSE   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic          supply_low,
   input  logic          pwr_ramp,
   input  logic [AW-1:0] addr_in,
   input  logic [DW-1:0] data_in,
   output logic          cmd_wr,
   output logic [AW-1:0] cmd_addr,
   output logic [DW-1:0] cmd_data,
   output logic          rd_reset_req
);
   // enables idle high, flags idle low
   localparam logic [NUM_PINS-1:0] PIN_IDLE = NUM_PINS'(7);

   generate
      if (AW < 1 || DW < 1) begin : g_bad_bus
         $error("flash_wr_gate: AW and DW must be at least 1");
      end
   endgenerate

   logic [NUM_PINS-1:0] raw_pins;
   logic [NUM_PINS-1:0] sync_pins;
   logic [NUM_ENAB-1:0] filt_en;

   always_comb begin
      raw_pins           = '0;
      raw_pins[PIN_CE]   = ce_n;
      raw_pins[PIN_WE]   = we_n;
      raw_pins[PIN_OE]   = oe_n;
      raw_pins[PIN_LOW]  = supply_low;
      raw_pins[PIN_RAMP] = pwr_ramp;
   end

   fwg_sync #(
      .W       (NUM_PINS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_pins),
      .q     (sync_pins)
   );

   generate
      for (genvar g = 0; g < NUM_ENAB; g++) begin : g_filt
         fwg_deglitch #(
            .MIN_PULSE (MIN_PULSE),
            .RST_VAL   (1'b1)
         ) u_dg (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (sync_pins[g]),
            .dout  (filt_en[g])
         );
      end
   endgenerate

   fwg_qualify #(
      .AW (AW),
      .DW (DW)
   ) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .f_ce_n   (filt_en[PIN_CE]),
      .f_we_n   (filt_en[PIN_WE]),
      .f_oe_n   (filt_en[PIN_OE]),
      .lock     (sync_pins[PIN_LOW]),
      .ramp     (sync_pins[PIN_RAMP]),
      .addr_in  (addr_in),
      .data_in  (data_in),
      .cmd_wr   (cmd_wr),
      .cmd_addr (cmd_addr),
      .cmd_data (cmd_data)
   );

   assign rd_reset_req = sync_pins[PIN_LOW];

   AST_NO_STROBE_WHEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |-> !$past(rd_reset_req)); // R3
endmodule

// File: tb/flash_wr_gate_test.sv
`timescale 1ns/1ps
module flash_wr_gate_test;
   localparam int AW  = 8;
   localparam int DW  = 8;
   localparam int SS  = 2;
   localparam int MP  = 3;
   localparam int LAT = SS + MP;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic          supply_low = 1'b0, pwr_ramp = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic [DW-1:0] data_in = '0;
   logic          cmd_wr;
   logic [AW-1:0] cmd_addr;
   logic [DW-1:0] cmd_data;
   logic          rd_reset_req;

   int n_chk = 0, n_fail = 0, n_wr = 0;
   logic [AW-1:0] cap_a = '0;
   logic [DW-1:0] cap_d = '0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   flash_wr_gate #(.AW(AW), .DW(DW), .SYNC_STAGES(SS), .MIN_PULSE(MP)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
      .supply_low(supply_low), .pwr_ramp(pwr_ramp),
      .addr_in(addr_in), .data_in(data_in),
      .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .rd_reset_req(rd_reset_req)
   );

   always @(negedge clk) begin
      if (rst_n && cmd_wr) begin
         n_wr  = n_wr + 1;
         cap_a = cmd_addr;
         cap_d = cmd_data;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pins(input logic c, input logic w, input logic o);
      ce_n = c; we_n = w; oe_n = o;
   endtask

   task automatic full_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      addr_in = a; data_in = d;
      pins(0, 0, 1); idle(12);
      we_n = 1;      idle(12);
      ce_n = 1;      idle(10);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int base;
      idle(4);
      rst_n = 1'b1;
      idle(12);
      // R11 reset state
      check("R11 cmd_wr", int'(cmd_wr), 0);
      check("R11 rd_reset_req", int'(rd_reset_req), 0);
      check("R11 no strobe", n_wr, 0);

      // R10 / R1 / R9 exact latency
      addr_in = 8'h5A; data_in = 8'hC3;
      pins(0, 0, 1); idle(12);
      we_n = 1'b1;
      repeat (LAT) @(posedge clk); #1;
      check("R10 early", int'(cmd_wr), 0);
      @(posedge clk); #1;
      check("R10 due", int'(cmd_wr), 1);
      check("R9 addr", int'(cmd_addr), 'h5A);
      check("R9 data", int'(cmd_data), 'hC3);
      @(posedge clk); #1;
      check("R1 one wide", int'(cmd_wr), 0);
      @(negedge clk);
      ce_n = 1'b1; addr_in = 8'h11; data_in = 8'h22; idle(12);
      check("R9 held addr", int'(cmd_addr), 'h5A);
      check("R9 held data", int'(cmd_data), 'hC3);

      // R1 R2 R3 sweep of enable combinations with and without lockout
      for (int lk = 0; lk < 2; lk++) begin
         for (int c = 0; c < 8; c++) begin
            base = n_wr;
            supply_low = lk[0];
            idle(4);
            pins(c[0], c[1], c[2]); idle(12);
            pins(1, 1, 1);          idle(12);
            supply_low = 1'b0;      idle(6);
            check((c == 4 && lk == 0) ? "R1 combo" : (lk == 1 ? "R3 combo" : "R2 combo"),
                  n_wr - base, (c == 4 && lk == 0) ? 1 : 0);
         end
      end

      // R4 lockout request latency
      supply_low = 1'b1;
      repeat (SS - 1) @(posedge clk); #1;
      check("R4 early", int'(rd_reset_req), 0);
      @(posedge clk); #1;
      check("R4 due", int'(rd_reset_req), 1);
      @(negedge clk); supply_low = 1'b0;
      repeat (SS) @(posedge clk); #1;
      check("R4 clear", int'(rd_reset_req), 0);
      idle(4);

      // R3 abort of an open cycle, R5 no write after lockout ends
      base = n_wr;
      pins(0, 0, 1); idle(12);
      supply_low = 1'b1; idle(6);
      supply_low = 1'b0; idle(12);
      pins(1, 1, 1); idle(12);
      check("R3 abort", n_wr - base, 0);
      base = n_wr;
      supply_low = 1'b1; idle(4);
      pins(0, 0, 1); idle(12);
      supply_low = 1'b0; idle(12);
      we_n = 1'b1; idle(12); ce_n = 1'b1; idle(8);
      check("R5 stale", n_wr - base, 0);
      base = n_wr;
      full_write(8'h3C, 8'h96);
      check("R5 fresh", n_wr - base, 1);
      check("R5 addr", int'(cap_a), 'h3C);

      // R6 suppression after ramp with enables low, R7 recovery
      base = n_wr;
      pwr_ramp = 1'b1; pins(0, 0, 1); idle(12);
      pwr_ramp = 1'b0; idle(8);
      we_n = 1'b1; idle(12); ce_n = 1'b1; idle(10);
      check("R6 swallowed", n_wr - base, 0);
      base = n_wr;
      full_write(8'hA5, 8'h5A);
      check("R7 next write", n_wr - base, 1);
      base = n_wr;
      pwr_ramp = 1'b1; idle(8); pwr_ramp = 1'b0; idle(6);
      full_write(8'h0F, 8'hF0);
      check("R7 ramp idle", n_wr - base, 1);

      // R8 short pulses on WE and CE
      for (int s = 0; s < 2; s++) begin
         for (int p = 1; p <= MP + 1; p++) begin
            base = n_wr;
            if (s == 0) ce_n = 1'b0; else we_n = 1'b0;
            idle(12);
            if (s == 0) we_n = 1'b0; else ce_n = 1'b0;
            idle(p);
            if (s == 0) we_n = 1'b1; else ce_n = 1'b1;
            idle(12);
            pins(1, 1, 1); idle(10);
            check("R8 enable pulse", n_wr - base, (p >= MP) ? 1 : 0);
         end
      end
      // R8 output-enable pulse inside an open cycle
      for (int p = 1; p <= MP + 1; p++) begin
         base = n_wr;
         pins(0, 0, 1); idle(12);
         oe_n = 1'b0; idle(p); oe_n = 1'b1; idle(12);
         pins(1, 1, 1); idle(10);
         check("R8 oe pulse", n_wr - base, (p < MP) ? 1 : 0);
      end

      // R9 capture sweep
      for (int i = 0; i < 6; i++) begin
         full_write(AW'(i * 37 + 5), DW'(i * 91 + 17));
         check("R9 sweep addr", int'(cap_a), (i * 37 + 5) % 256);
         check("R9 sweep data", int'(cap_d), (i * 91 + 17) % 256);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule